// File: doc/BRIEF.md
# SPI Buffer Status Flag Tracker

This block watches the handoff events around a double-buffered SPI engine and keeps the flags a host reads to learn how far its transmit and receive buffers have filled. It turns host read and write strobes, shift-register load and completion pulses, receive-complete pulses and error events into one 16-bit status word. It also returns a halt request to the engine while an unacknowledged transmit underrun is pending.

There are two buffering modes. In single-entry mode the empty flags are small state bits that move on each handoff event. In FIFO mode they are decoded straight from the 6-bit element counts that the FIFO storage supplies. Frame error, receive overflow and, unless underruns are ignored, transmit underrun are sticky. Software clears them by writing a word with a 1 in the flag's bit position. With underruns ignored, the underrun bit shows the live condition and never stops the engine.

Top module: `spi_stat_tracker`

## Requirements
- R1: The status word has frame error at bit 12, busy at bit 11, underrun at bit 8, shift-register-empty at bit 7, receive overflow at bit 6, RX empty at bit 5, TX empty at bit 3, TX full at bit 1 and RX full at bit 0. Every other bit always reads 0.
- R2: After reset, with idle inputs in single-entry mode (`fifo_mode`=0), the status word is 16'h00A8. RX empty, TX empty and shift-register-empty are 1; all other flags are 0.
- R3: In single-entry mode RX empty falls in the cycle after `rx_done` and rises in the cycle after `host_rd`. When both occur in one cycle, `rx_done` wins and the flag is 0.
- R4: In single-entry mode TX empty falls in the cycle after `host_wr` and rises in the cycle after `tx_load`. When both occur in one cycle, `host_wr` wins and the flag is 0.
- R5: In FIFO mode (`fifo_mode`=1), RX/TX empty is 1 exactly when `rx_cnt`/`tx_cnt` is 0. RX/TX full is 1 exactly when the count is at least FIFO_DEPTH. Both follow the count in the same cycle. In single-entry mode each full flag is the inverse of its empty flag.
- R6: Receive overflow becomes 1 in the cycle after `rx_done` arrives while RX full reads 1. It then stays 1 until a clear write with `clr_data[6]`=1.
- R7: Frame error becomes 1 in the cycle after `frm_err` and stays 1 until a clear write with `clr_data[12]`=1.
- R8: When a set event and a clear write for the same sticky flag (frame error, overflow, underrun) fall in one cycle, the flag ends up 1.
- R9: The shift register counts as loaded from the cycle after `tx_load` until the cycle after `tx_sent`; `tx_load` wins a tie. Shift-register-empty is 1 exactly when TX empty is 1 and the shift register is not loaded.
- R10: Busy equals `enable` AND (shift register loaded OR `xfer_active`).
- R11: With `ign_urun`=0 and `enable`=1, `urun_cond` makes the underrun bit 1 from the next cycle. The bit holds until a clear write with `clr_data[8]`=1, and `xfer_halt` is 1 while it is set.
- R12: With `ign_urun`=1, the underrun bit equals `enable` AND `urun_cond` in the same cycle. `xfer_halt` is 0, and `urun_cond` leaves no sticky state behind.
- R13: While `enable` is 0 the underrun bit and `xfer_halt` are 0, and the sticky underrun is cleared by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| ign_urun | input | 1 | 1 = underrun shown live and never halts |
| fifo_mode | input | 1 | 0 = single-entry buffers, 1 = FIFO counts |
| host_rd | input | 1 | Host read of the receive data buffer |
| host_wr | input | 1 | Host write of the transmit data buffer |
| tx_load | input | 1 | TX buffer moved into the transmit shift register |
| tx_sent | input | 1 | Transmit shift register finished sending |
| rx_done | input | 1 | Complete word received and moved toward the RX buffer |
| xfer_active | input | 1 | Engine is in a transfer |
| frm_err | input | 1 | Frame error event |
| urun_cond | input | 1 | Transmit underrun condition |
| clr_wr | input | 1 | Status clear write strobe |
| clr_data | input | 16 | Clear mask; 1 in bit 12, 6 or 8 clears that flag |
| tx_cnt | input | CNT_W | TX FIFO element count |
| rx_cnt | input | CNT_W | RX FIFO element count |
| status | output | 16 | Status word |
| xfer_halt | output | 1 | Request to stop TX/RX activity |

## Verification
Several functions can act in the same cycle. The collisions that matter are a hardware set meeting a software clear of the same sticky flag, and a buffer fill event meeting a drain event. The bench provokes both with random stimulus whose clear-write rate is high. It also runs a directed phase that fires `frm_err`, `rx_done` while full, and `urun_cond` together with clear writes for those same bits. A behavioural model applies set-over-clear and fill-over-drain on its own and compares every field after each edge.

// File: rtl/spi_stat_pkg.sv
`timescale 1ns/1ps
package spi_stat_pkg;
  localparam int STAT_W = 16;
  localparam int B_FRM  = 12;
  localparam int B_BUSY = 11;
  localparam int B_TUR  = 8;
  localparam int B_SRMT = 7;
  localparam int B_ROV  = 6;
  localparam int B_RBE  = 5;
  localparam int B_TBE  = 3;
  localparam int B_TBF  = 1;
  localparam int B_RBF  = 0;

  typedef struct packed {
    logic frm;
    logic busy;
    logic tur;
    logic srmt;
    logic rov;
    logic rbe;
    logic tbe;
    logic tbf;
    logic rbf;
  } stat_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(stat_flags_t f);
    logic [STAT_W-1:0] w;
    w         = '0;
    w[B_FRM]  = f.frm;
    w[B_BUSY] = f.busy;
    w[B_TUR]  = f.tur;
    w[B_SRMT] = f.srmt;
    w[B_ROV]  = f.rov;
    w[B_RBE]  = f.rbe;
    w[B_TBE]  = f.tbe;
    w[B_TBF]  = f.tbf;
    w[B_RBF]  = f.rbf;
    return w;
  endfunction

  // sticky update: set dominates clear, forced clear dominates both
  function automatic logic sticky_next(logic q, logic force_clr, logic set_e, logic clr_e);
    if (force_clr)  return 1'b0;
    if (set_e)      return 1'b1;
    if (clr_e)      return 1'b0;
    return q;
  endfunction
endpackage

// File: rtl/spi_buf_track.sv
`timescale 1ns/1ps
module spi_buf_track #(
  parameter int CNT_W = 6,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             fill_evt,
  input  logic             drain_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);
  localparam logic [CNT_W:0] DEPTH_V = (CNT_W+1)'(DEPTH);

  logic single_empty_q;
  logic cnt_zero;
  logic cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         single_empty_q <= 1'b1;
    else if (fill_evt)  single_empty_q <= 1'b0;
    else if (drain_evt) single_empty_q <= 1'b1;
  end

  assign cnt_zero = (cnt == '0);
  assign cnt_full = ({1'b0, cnt} >= DEPTH_V);

  always_comb begin
    if (fifo_mode) begin
      empty = cnt_zero;
      full  = cnt_full;
    end else begin
      empty = single_empty_q;
      full  = ~single_empty_q;
    end
  end
endmodule

// File: rtl/spi_sticky_flag.sv
`timescale 1ns/1ps
module spi_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr,
  input  logic set_evt,
  input  logic clr_evt,
  output logic q
);
  import spi_stat_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, force_clr, set_evt, clr_evt);
  end
endmodule

// File: rtl/spi_stat_tracker.sv
`timescale 1ns/1ps
module spi_stat_tracker #(
  parameter int CNT_W      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enable,
  input  logic                           ign_urun,
  input  logic                           fifo_mode,
  input  logic                           host_rd,
  input  logic                           host_wr,
  input  logic                           tx_load,
  input  logic                           tx_sent,
  input  logic                           rx_done,
  input  logic                           xfer_active,
  input  logic                           frm_err,
  input  logic                           urun_cond,
  input  logic                           clr_wr,
  input  logic [spi_stat_pkg::STAT_W-1:0] clr_data,
  input  logic [CNT_W-1:0]               tx_cnt,
  input  logic [CNT_W-1:0]               rx_cnt,
  output logic [spi_stat_pkg::STAT_W-1:0] status,
  output logic                           xfer_halt
);
  import spi_stat_pkg::*;

  logic tx_empty, tx_full, rx_empty, rx_full;
  logic sr_loaded_q;
  logic frm_q, rov_q, tur_q;

  // named internal events
  logic rov_set_evt, frm_clr_evt, rov_clr_evt, tur_clr_evt, tur_set_evt, tur_force_clr;
  stat_flags_t flags;

  spi_buf_track #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_rx_buf (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .fill_evt(rx_done), .drain_evt(host_rd), .cnt(rx_cnt),
    .empty(rx_empty), .full(rx_full));

  spi_buf_track #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_tx_buf (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .fill_evt(host_wr), .drain_evt(tx_load), .cnt(tx_cnt),
    .empty(tx_empty), .full(tx_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_loaded_q <= 1'b0;
    else if (tx_load) sr_loaded_q <= 1'b1;
    else if (tx_sent) sr_loaded_q <= 1'b0;
  end

  assign rov_set_evt   = rx_done & rx_full;
  assign frm_clr_evt   = clr_wr & clr_data[B_FRM];
  assign rov_clr_evt   = clr_wr & clr_data[B_ROV];
  assign tur_clr_evt   = clr_wr & clr_data[B_TUR];
  assign tur_set_evt   = enable & ~ign_urun & urun_cond;
  assign tur_force_clr = ~enable;

  spi_sticky_flag u_frm (.clk(clk), .rst_n(rst_n), .force_clr(1'b0),
    .set_evt(frm_err), .clr_evt(frm_clr_evt), .q(frm_q));
  spi_sticky_flag u_rov (.clk(clk), .rst_n(rst_n), .force_clr(1'b0),
    .set_evt(rov_set_evt), .clr_evt(rov_clr_evt), .q(rov_q));
  spi_sticky_flag u_tur (.clk(clk), .rst_n(rst_n), .force_clr(tur_force_clr),
    .set_evt(tur_set_evt), .clr_evt(tur_clr_evt), .q(tur_q));

  always_comb begin
    flags.frm  = frm_q;
    flags.busy = enable & (sr_loaded_q | xfer_active);
    flags.tur  = ign_urun ? (enable & urun_cond) : (enable & tur_q);
    flags.srmt = tx_empty & ~sr_loaded_q;
    flags.rov  = rov_q;
    flags.rbe  = rx_empty;
    flags.tbe  = tx_empty;
    flags.tbf  = tx_full;
    flags.rbf  = rx_full;
  end

  assign status    = pack_status(flags);
  assign xfer_halt = ~ign_urun & enable & tur_q;
endmodule

// File: rtl/spi_stat_tracker_chk.sv
`timescale 1ns/1ps
module spi_stat_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        ign_urun,
  input logic        fifo_mode,
  input logic        rx_done,
  input logic        frm_err,
  input logic        clr_wr,
  input logic [15:0] clr_data,
  input logic [15:0] status,
  input logic        xfer_halt
);
  localparam logic [15:0] USED = 16'h19EB;

  p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED) == 16'h0);
  p_rx_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && rx_done) |=> (fifo_mode || !status[5]));
  p_empty_full_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[5] && status[0]) && !(status[3] && status[1]));
  p_rov_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !(clr_wr && clr_data[6])) |=> status[6]);
  p_frm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> status[12]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status[0] && clr_wr && clr_data[6]) |=> status[6]);
  p_srmt_needs_tbe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> status[3]);
  p_halt_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_halt |-> status[8]);
  p_ign_no_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ign_urun |-> !xfer_halt);
  p_dis_no_tur_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!status[8] && !xfer_halt));
endmodule

bind spi_stat_tracker spi_stat_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ign_urun(ign_urun),
  .fifo_mode(fifo_mode), .rx_done(rx_done), .frm_err(frm_err),
  .clr_wr(clr_wr), .clr_data(clr_data), .status(status), .xfer_halt(xfer_halt));

// File: tb/tb_spi_stat_tracker.sv
`timescale 1ns/1ps
module tb_spi_stat_tracker;
  localparam int CNT_W = 6;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, ign_urun = 1'b0, fifo_mode = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0, tx_load = 1'b0, tx_sent = 1'b0;
  logic rx_done = 1'b0, xfer_active = 1'b0, frm_err = 1'b0, urun_cond = 1'b0;
  logic clr_wr = 1'b0;
  logic [15:0] clr_data = '0;
  logic [CNT_W-1:0] tx_cnt = '0, rx_cnt = '0;
  logic [15:0] status;
  logic xfer_halt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  bit m_rxe, m_txe, m_sr, m_fe, m_rov, m_tur;

  spi_stat_tracker #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ign_urun(ign_urun),
    .fifo_mode(fifo_mode), .host_rd(host_rd), .host_wr(host_wr),
    .tx_load(tx_load), .tx_sent(tx_sent), .rx_done(rx_done),
    .xfer_active(xfer_active), .frm_err(frm_err), .urun_cond(urun_cond),
    .clr_wr(clr_wr), .clr_data(clr_data), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .status(status), .xfer_halt(xfer_halt));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_txe();
    return fifo_mode ? (int'(tx_cnt) == 0) : m_txe;
  endfunction
  function automatic bit exp_rxe();
    return fifo_mode ? (int'(rx_cnt) == 0) : m_rxe;
  endfunction
  function automatic bit exp_txf();
    return fifo_mode ? (int'(tx_cnt) >= DEPTH) : !m_txe;
  endfunction
  function automatic bit exp_rxf();
    return fifo_mode ? (int'(rx_cnt) >= DEPTH) : !m_rxe;
  endfunction

  task automatic compare_all();
    bit tur_exp;
    tur_exp = ign_urun ? (enable && urun_cond) : (enable && m_tur);
    chk("R1 unused bits", status & ~16'h19EB, 16'h0);
    chk("R7 frame error", 16'(status[12]), 16'(m_fe));
    chk("R10 busy", 16'(status[11]), 16'(enable && (m_sr || xfer_active)));
    chk(ign_urun ? "R12 live underrun" : "R11 sticky underrun", 16'(status[8]), 16'(tur_exp));
    chk("R9 shift empty", 16'(status[7]), 16'(exp_txe() && !m_sr));
    chk("R6 overflow", 16'(status[6]), 16'(m_rov));
    chk(fifo_mode ? "R5 rx empty" : "R3 rx empty", 16'(status[5]), 16'(exp_rxe()));
    chk(fifo_mode ? "R5 tx empty" : "R4 tx empty", 16'(status[3]), 16'(exp_txe()));
    chk("R5 tx full", 16'(status[1]), 16'(exp_txf()));
    chk("R5 rx full", 16'(status[0]), 16'(exp_rxf()));
    chk(enable ? "R11 halt" : "R13 halt", 16'(xfer_halt), 16'(!ign_urun && enable && m_tur));
  endtask

  task automatic model_edge();
    bit rxf;
    rxf = exp_rxf();
    // R8: set beats clear in each sticky flag
    if (frm_err) m_fe = 1; else if (clr_wr && clr_data[12]) m_fe = 0;
    if (rx_done && rxf) m_rov = 1; else if (clr_wr && clr_data[6]) m_rov = 0;
    if (!enable) m_tur = 0;
    else if (!ign_urun && urun_cond) m_tur = 1;
    else if (clr_wr && clr_data[8]) m_tur = 0;
    if (rx_done) m_rxe = 0; else if (host_rd) m_rxe = 1;
    if (host_wr) m_txe = 0; else if (tx_load) m_txe = 1;
    if (tx_load) m_sr = 1; else if (tx_sent) m_sr = 0;
  endtask

  function automatic logic [CNT_W-1:0] pick_cnt();
    case ($urandom_range(0, 4))
      0: return '0;
      1: return CNT_W'(DEPTH);
      2: return CNT_W'(DEPTH - 1);
      3: return '1;
      default: return CNT_W'($urandom_range(1, DEPTH));
    endcase
  endfunction

  // p: pulse probability in percent, c: clear-write probability
  task automatic run_phase(int cycles, int p, int c);
    for (int i = 0; i < cycles; i++) begin
      host_rd     = ($urandom_range(0, 99) < p);
      host_wr     = ($urandom_range(0, 99) < p);
      tx_load     = ($urandom_range(0, 99) < p);
      tx_sent     = ($urandom_range(0, 99) < p);
      rx_done     = ($urandom_range(0, 99) < p);
      xfer_active = ($urandom_range(0, 99) < 40);
      frm_err     = ($urandom_range(0, 99) < p / 3);
      urun_cond   = ($urandom_range(0, 99) < p / 2);
      clr_wr      = ($urandom_range(0, 99) < c);
      clr_data    = 16'($urandom());
      if (fifo_mode && $urandom_range(0, 3) == 0) begin
        tx_cnt = pick_cnt();
        rx_cnt = pick_cnt();
      end
      #1 compare_all();
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic idle_inputs();
    host_rd = 0; host_wr = 0; tx_load = 0; tx_sent = 0; rx_done = 0;
    xfer_active = 0; frm_err = 0; urun_cond = 0; clr_wr = 0; clr_data = '0;
  endtask

  // one cycle with given events, then compare after the edge
  task automatic one(bit rd, bit wr, bit ld, bit rx, bit fe, bit ur, bit cw, logic [15:0] cd);
    host_rd = rd; host_wr = wr; tx_load = ld; rx_done = rx; frm_err = fe;
    urun_cond = ur; clr_wr = cw; clr_data = cd; tx_sent = 0; xfer_active = 0;
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle_inputs();
    #1 compare_all();
  endtask

  initial begin
    m_rxe = 1; m_txe = 1; m_sr = 0; m_fe = 0; m_rov = 0; m_tur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R2 reset word", status, 16'h00A8);
    chk("R2 reset halt", 16'(xfer_halt), 16'h0);
    @(negedge clk);
    enable = 1;

    // directed single-entry handoffs
    one(0, 0, 0, 1, 0, 0, 0, 16'h0);      // R3 rx fill
    one(1, 0, 0, 1, 0, 0, 1, 16'h0040);   // R8 overflow set with clear, R3 tie
    chk("R8 overflow set beats clear", 16'(status[6]), 16'h1);
    one(0, 1, 1, 0, 0, 0, 0, 16'h0);      // R4 tie write wins, R9 load
    chk("R4 write beats load", 16'(status[3]), 16'h0);
    one(0, 0, 0, 0, 1, 1, 1, 16'h1100);   // R8 frame/underrun set with clear
    chk("R8 frame set beats clear", 16'(status[12]), 16'h1);
    chk("R11 halt after underrun", 16'(xfer_halt), 16'h1);
    one(0, 0, 0, 0, 0, 0, 1, 16'h1140);   // R6 R7 R11 clears
    chk("R7 frame cleared", 16'(status[12]), 16'h0);

    run_phase(1500, 20, 25);
    ign_urun = 1;
    run_phase(600, 20, 25);                // R12
    ign_urun = 0;
    fifo_mode = 1;
    run_phase(1500, 20, 25);               // R5
    for (int k = 0; k < 400; k++) begin    // R13 enable toggling
      enable = ($urandom_range(0, 2) != 0);
      ign_urun = ($urandom_range(0, 3) == 0);
      fifo_mode = ($urandom_range(0, 1) == 1);
      run_phase(3, 30, 30);
    end
    enable = 1; ign_urun = 0; fifo_mode = 0;
    run_phase(500, 40, 60);                // dense collisions

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule